// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gating

This block sits after the clock generators of a board-level clock source and decides, for each generated clock, whether it reaches its output pin. The clocks arrive as inputs: a processor-rate clock, a peripheral-bus (PCI) clock, a slow reference clock and a memory clock. Each group has gated members and one free-running member. An active-low processor stop input halts the gated processor clocks, the gated reference-derived interrupt-controller clock and all gated memory clocks. An active-low PCI stop input halts the gated PCI clocks. Every output also has a register enable bit; a cleared bit holds that output low.

All gating is synchronous and happens in each clock's own domain. A stop or enable request is first resampled on rising edges of the target clock. A gate flop clocked on the falling edge then feeds an AND gate, so no output ever starts or ends in the middle of a high phase. A two-bit mode input selects a drive-disable code, modelled as a single registered output-enable that the pad ring uses to float every clock pin.

Top module: `clkgate_top`

## Requirements
- R1: While `rst_i` is held high, every clock output stays low and `drv_oe_o` is low.
- R2: When `cpu_stop_n_i` falls, each enabled gated processor output gives exactly two more rising edges, on the first and second rising edges of `clk_cpu_i` after the change, and then stays low.
- R3: When `cpu_stop_n_i` rises, each enabled gated processor output stays low through the first two rising edges of `clk_cpu_i` after the change and gives its first pulse on the third.
- R4: Every high pulse on a gated output lasts exactly one full high phase of its source clock, at stop, at restart and in between.
- R5: `pci_stop_n_i` is sampled on rising edges of `clk_pci_i`. After it falls, each enabled gated PCI output gives exactly one more rising edge (the first `clk_pci_i` edge after the change). After it rises, the first pulse comes on the second `clk_pci_i` edge.
- R6: The free-running outputs `cpu_free_o`, `pci_free_o`, `apic_free_o` and `mem_free_o` keep toggling while either stop input is low, as long as their enable bits are set.
- R7: `apic_clk_o` and every bit of `mem_clk_o` stop low while `cpu_stop_n_i` is low and run again after it returns high. `pci_stop_n_i` has no effect on them.
- R8: A cleared enable bit holds its output low regardless of the stop inputs: `cpu_en_i[i]` drives `cpu_clk_o[i]`, `pci_en_i[i]` drives `pci_clk_o[i]`, `mem_en_i[b]` drives `mem_clk_o[4*b+3:4*b]`, and each free output has its own single enable bit.
- R9: `drv_oe_o` is low on the `clk_cpu_i` edge after `mode_i` is seen equal to 2'b11 and high after any other code is seen.
- R10: `pci_stop_n_i` has no effect on the processor group, and `cpu_stop_n_i` has no effect on the PCI group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_i | input | 1 | Processor-rate source clock |
| clk_pci_i | input | 1 | PCI-rate source clock |
| clk_ref_i | input | 1 | Reference source clock for the interrupt-controller outputs |
| clk_mem_i | input | 1 | Memory source clock |
| rst_i | input | 1 | Synchronous active-high reset, held across edges of every source clock |
| cpu_stop_n_i | input | 1 | Active-low stop for the gated processor, interrupt and memory outputs |
| pci_stop_n_i | input | 1 | Active-low stop for the gated PCI outputs |
| mode_i | input | 2 | Operating mode; 2'b11 floats all clock pins |
| cpu_en_i | input | N_CPU | Enable bits for the gated processor outputs |
| cpu_free_en_i | input | 1 | Enable for the free-running processor output |
| pci_en_i | input | N_PCI | Enable bits for the gated PCI outputs |
| pci_free_en_i | input | 1 | Enable for the free-running PCI output |
| apic_en_i | input | 1 | Enable for the gated interrupt-controller output |
| apic_free_en_i | input | 1 | Enable for the free-running interrupt-controller output |
| mem_en_i | input | N_MEM_BANK | Enable bits, one per bank of memory outputs |
| mem_free_en_i | input | 1 | Enable for the free-running memory output |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| cpu_free_o | output | 1 | Free-running processor clock |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| pci_free_o | output | 1 | Free-running PCI clock |
| apic_clk_o | output | 1 | Gated interrupt-controller clock |
| apic_free_o | output | 1 | Free-running interrupt-controller clock |
| mem_clk_o | output | N_MEM_BANK*MEM_PER_BANK | Gated memory clocks |
| mem_free_o | output | 1 | Free-running memory clock |
| drv_oe_o | output | 1 | Registered pad drive enable for every clock output |

## Verification
The assertions assume that the stop, enable and mode inputs are quasi-static: each one changes at most once per source-clock period and well away from the edges of the domain that samples it, and reset is held long enough for every domain to see several edges. The stimulus meets this by changing inputs two nanoseconds after a rising edge of the relevant clock and by holding each setting for many cycles. The latency windows in the properties count sampled cycles since the last change, so they only apply once an input has been steady for that many cycles after reset.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  // operating mode codes seen on mode_i
  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_BYPASS = 2'b01,
    MODE_SPREAD = 2'b10,
    MODE_FLOAT  = 2'b11
  } drv_mode_e;

  localparam int unsigned CPU_SYNC_STAGES = 2;
  localparam int unsigned PCI_SYNC_STAGES = 1;
endpackage

// File: rtl/clkgate_cell.sv
// One gated clock: request resampled on rising edges, gate flop on the
// falling edge, AND with the source clock.
module clkgate_cell #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  output logic clk_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   gate_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= run_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= {sync_q[SYNC_STAGES-2:0], run_i};
      end
    end
  endgenerate

  // updated only while the clock is low, so the AND never cuts a pulse
  always_ff @(negedge clk_i) begin
    if (rst_i) gate_q <= 1'b0;
    else       gate_q <= sync_q[LAST];
  end

  assign clk_o = clk_i & gate_q;
endmodule

// File: rtl/clkgate_bank.sv
// A row of gated clocks that share one source clock.
module clkgate_bank #(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] run_i,
  output logic [WIDTH-1:0] clk_o
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .run_i (run_i[i]),
        .clk_o (clk_o[i])
      );
    end
  endgenerate
endmodule

// File: rtl/clkgate_top.sv
module clkgate_top
  import clkgate_pkg::*;
#(
  parameter int unsigned N_CPU         = 2,
  parameter int unsigned N_PCI         = 6,
  parameter int unsigned N_MEM_BANK    = 4,
  parameter int unsigned MEM_PER_BANK  = 4
) (
  input  logic                                 clk_cpu_i,
  input  logic                                 clk_pci_i,
  input  logic                                 clk_ref_i,
  input  logic                                 clk_mem_i,
  input  logic                                 rst_i,
  input  logic                                 cpu_stop_n_i,
  input  logic                                 pci_stop_n_i,
  input  logic [1:0]                           mode_i,
  input  logic [N_CPU-1:0]                     cpu_en_i,
  input  logic                                 cpu_free_en_i,
  input  logic [N_PCI-1:0]                     pci_en_i,
  input  logic                                 pci_free_en_i,
  input  logic                                 apic_en_i,
  input  logic                                 apic_free_en_i,
  input  logic [N_MEM_BANK-1:0]                mem_en_i,
  input  logic                                 mem_free_en_i,
  output logic [N_CPU-1:0]                     cpu_clk_o,
  output logic                                 cpu_free_o,
  output logic [N_PCI-1:0]                     pci_clk_o,
  output logic                                 pci_free_o,
  output logic                                 apic_clk_o,
  output logic                                 apic_free_o,
  output logic [N_MEM_BANK*MEM_PER_BANK-1:0]   mem_clk_o,
  output logic                                 mem_free_o,
  output logic                                 drv_oe_o
);
  localparam int unsigned N_MEM = N_MEM_BANK * MEM_PER_BANK;

  logic [N_CPU-1:0] cpu_run;
  logic [N_PCI-1:0] pci_run;
  logic [N_MEM-1:0] mem_run;
  logic             apic_run;

  assign cpu_run  = cpu_en_i & {N_CPU{cpu_stop_n_i}};
  assign pci_run  = pci_en_i & {N_PCI{pci_stop_n_i}};
  assign apic_run = apic_en_i & cpu_stop_n_i;

  generate
    for (genvar m = 0; m < N_MEM; m++) begin : g_mem_run
      assign mem_run[m] = mem_en_i[m / MEM_PER_BANK] & cpu_stop_n_i;
    end
  endgenerate

  // processor group
  clkgate_bank #(.WIDTH(N_CPU), .SYNC_STAGES(CPU_SYNC_STAGES)) u_cpu (
    .clk_i (clk_cpu_i), .rst_i (rst_i), .run_i (cpu_run), .clk_o (cpu_clk_o)
  );
  clkgate_cell #(.SYNC_STAGES(CPU_SYNC_STAGES)) u_cpu_free (
    .clk_i (clk_cpu_i), .rst_i (rst_i), .run_i (cpu_free_en_i), .clk_o (cpu_free_o)
  );

  // PCI group: stop sampled once on the free-running PCI clock edge
  clkgate_bank #(.WIDTH(N_PCI), .SYNC_STAGES(PCI_SYNC_STAGES)) u_pci (
    .clk_i (clk_pci_i), .rst_i (rst_i), .run_i (pci_run), .clk_o (pci_clk_o)
  );
  clkgate_cell #(.SYNC_STAGES(PCI_SYNC_STAGES)) u_pci_free (
    .clk_i (clk_pci_i), .rst_i (rst_i), .run_i (pci_free_en_i), .clk_o (pci_free_o)
  );

  // interrupt-controller clocks on the reference domain
  clkgate_cell #(.SYNC_STAGES(CPU_SYNC_STAGES)) u_apic (
    .clk_i (clk_ref_i), .rst_i (rst_i), .run_i (apic_run), .clk_o (apic_clk_o)
  );
  clkgate_cell #(.SYNC_STAGES(CPU_SYNC_STAGES)) u_apic_free (
    .clk_i (clk_ref_i), .rst_i (rst_i), .run_i (apic_free_en_i), .clk_o (apic_free_o)
  );

  // memory clocks
  clkgate_bank #(.WIDTH(N_MEM), .SYNC_STAGES(CPU_SYNC_STAGES)) u_mem (
    .clk_i (clk_mem_i), .rst_i (rst_i), .run_i (mem_run), .clk_o (mem_clk_o)
  );
  clkgate_cell #(.SYNC_STAGES(CPU_SYNC_STAGES)) u_mem_free (
    .clk_i (clk_mem_i), .rst_i (rst_i), .run_i (mem_free_en_i), .clk_o (mem_free_o)
  );

  // pad drive enable, registered in the processor domain
  always_ff @(posedge clk_cpu_i) begin
    if (rst_i) drv_oe_o <= 1'b0;
    else       drv_oe_o <= (drv_mode_e'(mode_i) != MODE_FLOAT);
  end
endmodule

// File: rtl/clkgate_checker.sv
module clkgate_checker #(
  parameter int unsigned N_CPU = 2,
  parameter int unsigned N_PCI = 6
) (
  input logic             clk_cpu_i,
  input logic             clk_pci_i,
  input logic             rst_i,
  input logic             cpu_stop_n_i,
  input logic             pci_stop_n_i,
  input logic [1:0]       mode_i,
  input logic [N_CPU-1:0] cpu_en_i,
  input logic             cpu_free_en_i,
  input logic [N_CPU-1:0] cpu_clk_o,
  input logic             cpu_free_o,
  input logic [N_PCI-1:0] pci_clk_o,
  input logic             drv_oe_o
);
  // R1: reset drives pads off
  assert_reset_oe_R1: assert property (@(posedge clk_cpu_i)
    rst_i |=> !drv_oe_o);

  // R2: stop held for four falling-edge samples -> no high phase left
  assert_cpu_stopped_R2: assert property (@(negedge clk_cpu_i) disable iff (rst_i)
    (!cpu_stop_n_i && $past(!cpu_stop_n_i) && $past(!cpu_stop_n_i, 2) && $past(!cpu_stop_n_i, 3))
      |-> (cpu_clk_o == '0));

  // R5: PCI stop held for three samples -> PCI gated outputs low
  assert_pci_stopped_R5: assert property (@(negedge clk_pci_i) disable iff (rst_i)
    (!pci_stop_n_i && $past(!pci_stop_n_i) && $past(!pci_stop_n_i, 2))
      |-> (pci_clk_o == '0));

  // R6: free processor clock high in every high phase once enabled and out of reset
  assert_cpu_free_runs_R6: assert property (@(negedge clk_cpu_i) disable iff (rst_i)
    (cpu_free_en_i && $past(cpu_free_en_i) && $past(cpu_free_en_i, 2) && $past(cpu_free_en_i, 3)
     && !$past(rst_i) && !$past(rst_i, 2) && !$past(rst_i, 3))
      |-> cpu_free_o);

  // R8: a cleared enable bit keeps its output low
  assert_en_low_R8: assert property (@(negedge clk_cpu_i) disable iff (rst_i)
    (!cpu_en_i[0] && $past(!cpu_en_i[0]) && $past(!cpu_en_i[0], 2) && $past(!cpu_en_i[0], 3))
      |-> !cpu_clk_o[0]);

  // R9: float code turns the pad drive off on the next edge
  assert_float_R9: assert property (@(posedge clk_cpu_i) disable iff (rst_i)
    (mode_i == 2'b11) |=> !drv_oe_o);
endmodule

bind clkgate_top clkgate_checker #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_chk (.*);

// File: tb/sim_clkgate_top.sv
`timescale 1ns/1ps
module sim_clkgate_top;
  localparam int N_CPU = 2, N_PCI = 6, N_MB = 4, PER_B = 4;
  localparam int N_MEM = N_MB * PER_B;

  logic clk_cpu = 0, clk_pci = 0, clk_ref = 0, clk_mem = 0;
  logic rst = 1, cpu_stop_n = 1, pci_stop_n = 1;
  logic [1:0] mode = 2'b00;
  logic [N_CPU-1:0] cpu_en = '1;
  logic [N_PCI-1:0] pci_en = '1;
  logic [N_MB-1:0]  mem_en = '1;
  logic cpu_free_en = 1, pci_free_en = 1, apic_en = 1, apic_free_en = 1, mem_free_en = 1;
  logic [N_CPU-1:0] cpu_o;
  logic [N_PCI-1:0] pci_o;
  logic [N_MEM-1:0] mem_o;
  logic cpu_f, pci_f, apic_o, apic_f, mem_f, oe;

  always #5  clk_cpu = ~clk_cpu;
  always #15 clk_pci = ~clk_pci;
  always #35 clk_ref = ~clk_ref;
  always #6  clk_mem = ~clk_mem;

  clkgate_top #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_MEM_BANK(N_MB), .MEM_PER_BANK(PER_B)) u0 (
    .clk_cpu_i(clk_cpu), .clk_pci_i(clk_pci), .clk_ref_i(clk_ref), .clk_mem_i(clk_mem),
    .rst_i(rst), .cpu_stop_n_i(cpu_stop_n), .pci_stop_n_i(pci_stop_n), .mode_i(mode),
    .cpu_en_i(cpu_en), .cpu_free_en_i(cpu_free_en), .pci_en_i(pci_en), .pci_free_en_i(pci_free_en),
    .apic_en_i(apic_en), .apic_free_en_i(apic_free_en), .mem_en_i(mem_en), .mem_free_en_i(mem_free_en),
    .cpu_clk_o(cpu_o), .cpu_free_o(cpu_f), .pci_clk_o(pci_o), .pci_free_o(pci_f),
    .apic_clk_o(apic_o), .apic_free_o(apic_f), .mem_clk_o(mem_o), .mem_free_o(mem_f),
    .drv_oe_o(oe));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // rising-edge counters on outputs
  int e_cpu0 = 0, e_cpu1 = 0, e_cpuf = 0, e_pci0 = 0, e_pcif = 0;
  int e_apic = 0, e_apicf = 0, e_mem0 = 0, e_mem15 = 0, e_memf = 0;
  always @(posedge cpu_o[0]) e_cpu0++;
  always @(posedge cpu_o[1]) e_cpu1++;
  always @(posedge cpu_f)    e_cpuf++;
  always @(posedge pci_o[0]) e_pci0++;
  always @(posedge pci_f)    e_pcif++;
  always @(posedge apic_o)   e_apic++;
  always @(posedge apic_f)   e_apicf++;
  always @(posedge mem_o[0]) e_mem0++;
  always @(posedge mem_o[15]) e_mem15++;
  always @(posedge mem_f)    e_memf++;

  // R4: pulse width monitor on gated outputs
  realtime t_cpu_up, t_pci_up;
  always @(posedge cpu_o[0]) t_cpu_up = $realtime;
  always @(negedge cpu_o[0]) if (!rst && ($realtime - t_cpu_up) != 5.0)
    chk(0, "R4 cpu pulse width (ps)", int'(($realtime - t_cpu_up) * 1000), 5000);
  always @(posedge pci_o[0]) t_pci_up = $realtime;
  always @(negedge pci_o[0]) if (!rst && ($realtime - t_pci_up) != 15.0)
    chk(0, "R4 pci pulse width (ps)", int'(($realtime - t_pci_up) * 1000), 15000);

  task automatic cpu_edges(input int n);
    repeat (n) @(posedge clk_cpu);
    #1;
  endtask
  task automatic pci_edges(input int n);
    repeat (n) @(posedge clk_pci);
    #1;
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk_ref);
    #3;
    chk(cpu_o == 0 && cpu_f == 0 && pci_o == 0 && pci_f == 0, "R1 cpu/pci outputs in reset", 0, 0);
    chk(apic_o == 0 && apic_f == 0 && mem_o == 0 && mem_f == 0, "R1 apic/mem outputs in reset", 0, 0);
    chk(oe == 0, "R1 drv_oe in reset", oe, 0);
    chk(e_cpuf == 0 && e_memf == 0, "R1 no edges in reset", e_cpuf + e_memf, 0);
    @(posedge clk_ref); #2; rst = 0;
    repeat (10) @(posedge clk_ref);
  endtask

  task automatic t_cpu_stop;
    int c;
    @(posedge clk_cpu); #2; cpu_stop_n = 0; c = e_cpu0;
    cpu_edges(2);
    chk(e_cpu0 - c == 2, "R2 edges after stop", e_cpu0 - c, 2);
    cpu_edges(6);
    chk(e_cpu0 - c == 2, "R2 stays low", e_cpu0 - c, 2);
    chk(e_cpu1 - c >= 0 && cpu_o == 0, "R2 all gated cpu low", cpu_o, 0);
    @(posedge clk_cpu); #2; cpu_stop_n = 1; c = e_cpu0;
    cpu_edges(2);
    chk(e_cpu0 - c == 0, "R3 silent two edges", e_cpu0 - c, 0);
    cpu_edges(1);
    chk(e_cpu0 - c == 1, "R3 first pulse on third edge", e_cpu0 - c, 1);
    cpu_edges(4);
    chk(e_cpu0 - c == 5, "R3 running after restart", e_cpu0 - c, 5);
  endtask

  task automatic t_pci_stop;
    int c, cc;
    @(posedge clk_pci); #2; pci_stop_n = 0; c = e_pci0; cc = e_cpu0;
    pci_edges(1);
    chk(e_pci0 - c == 1, "R5 one edge after stop", e_pci0 - c, 1);
    pci_edges(4);
    chk(e_pci0 - c == 1, "R5 stays low", e_pci0 - c, 1);
    chk(e_cpu0 - cc >= 14, "R10 cpu unaffected by pci stop", e_cpu0 - cc, 14);
    @(posedge clk_pci); #2; pci_stop_n = 1; c = e_pci0;
    pci_edges(1);
    chk(e_pci0 - c == 0, "R5 silent first edge", e_pci0 - c, 0);
    pci_edges(1);
    chk(e_pci0 - c == 1, "R5 first pulse on second edge", e_pci0 - c, 1);
  endtask

  task automatic t_free_and_groups;
    int f_c, f_p, f_a, f_m, g_p, g_a, g_m0, g_m15;
    @(posedge clk_pci); #2; pci_stop_n = 0; cpu_stop_n = 0;
    repeat (6) @(posedge clk_ref);
    #1;
    f_c = e_cpuf; f_p = e_pcif; f_a = e_apicf; f_m = e_memf;
    g_a = e_apic; g_m0 = e_mem0; g_m15 = e_mem15;
    repeat (4) @(posedge clk_ref);
    #1;
    chk(e_cpuf - f_c >= 20 && e_pcif - f_p >= 8, "R6 cpu/pci free run while stopped",
        e_cpuf - f_c, 28);
    chk(e_apicf - f_a == 4 && e_memf - f_m >= 20, "R6 apic/mem free run while stopped",
        e_apicf - f_a, 4);
    chk(e_apic == g_a && apic_o == 0, "R7 apic gated stopped", e_apic - g_a, 0);
    chk(e_mem0 == g_m0 && e_mem15 == g_m15 && mem_o == 0, "R7 mem gated stopped",
        e_mem0 - g_m0, 0);
    // only PCI stop low: cpu domain gated outputs must run
    @(posedge clk_pci); #2; cpu_stop_n = 1; g_p = e_pci0;
    repeat (6) @(posedge clk_ref);
    #1;
    g_a = e_apic; g_m0 = e_mem0;
    repeat (4) @(posedge clk_ref);
    #1;
    chk(e_apic - g_a == 4, "R7 apic runs with only pci stop", e_apic - g_a, 4);
    chk(e_mem0 - g_m0 >= 20, "R7 mem runs with only pci stop", e_mem0 - g_m0, 23);
    chk(e_pci0 == g_p, "R10 pci still stopped", e_pci0 - g_p, 0);
    // only cpu stop low: pci gated outputs must run
    @(posedge clk_pci); #2; pci_stop_n = 1; cpu_stop_n = 0;
    pci_edges(3); g_p = e_pci0;
    pci_edges(5);
    chk(e_pci0 - g_p == 5, "R10 pci unaffected by cpu stop", e_pci0 - g_p, 5);
    @(posedge clk_pci); #2; cpu_stop_n = 1;
    repeat (6) @(posedge clk_ref);
  endtask

  task automatic t_enables;
    int c0, c1, m0, m15, cf;
    @(posedge clk_cpu); #2; cpu_en = 2'b10; mem_en = 4'b1110;
    repeat (4) @(posedge clk_ref);
    #1;
    c0 = e_cpu0; c1 = e_cpu1; m0 = e_mem0; m15 = e_mem15;
    cpu_edges(10);
    chk(e_cpu0 == c0 && cpu_o[0] == 0, "R8 cpu_en[0]=0 holds low", e_cpu0 - c0, 0);
    chk(e_cpu1 - c1 == 10, "R8 cpu_en[1]=1 runs", e_cpu1 - c1, 10);
    chk(e_mem0 == m0, "R8 mem_en[0]=0 holds bank 0 low", e_mem0 - m0, 0);
    chk(e_mem15 - m15 >= 7, "R8 mem_en[3]=1 bank 3 runs", e_mem15 - m15, 8);
    @(posedge clk_cpu); #2; cpu_free_en = 0;
    cpu_edges(4); cf = e_cpuf;
    cpu_edges(6);
    chk(e_cpuf == cf, "R8 free enable cleared holds low", e_cpuf - cf, 0);
    @(posedge clk_cpu); #2; cpu_free_en = 1; cpu_en = '1; mem_en = '1;
    repeat (4) @(posedge clk_ref);
  endtask

  task automatic t_mode;
    @(posedge clk_cpu); #2; mode = 2'b11;
    cpu_edges(1);
    chk(oe == 0, "R9 float code disables drive", oe, 0);
    @(posedge clk_cpu); #2; mode = 2'b10;
    cpu_edges(1);
    chk(oe == 1, "R9 spread code drives", oe, 1);
    @(posedge clk_cpu); #2; mode = 2'b01;
    cpu_edges(1);
    chk(oe == 1, "R9 bypass code drives", oe, 1);
    @(posedge clk_cpu); #2; mode = 2'b00;
    cpu_edges(1);
  endtask

  initial begin
    t_reset;
    t_cpu_stop;
    t_pci_stop;
    t_free_and_groups;
    t_enables;
    t_mode;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      chk(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule